// File: doc/BRIEF.md
# In-band XON/XOFF Flow Controller

This block provides automatic software flow control for a serial receiver. It watches the fill level of the receive FIFO and compares it with two programmable marks. When the level climbs to the upper mark, it asks the transmitter to send a stop character. When the level later falls to the lower mark, it asks for a resume character. The two marks give hysteresis, so each crossing produces one request. A request stays pending until the transmitter acknowledges it.

In the same block, a character matcher compares every received character with a programmed special character. The matcher works only when enhanced mode and detection are both switched on. On a match it sets a sticky flag and raises an interrupt request. The interrupt is withdrawn when the interrupt status is read while this source is the one reported. The flag is cleared by its own clear strobe.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes low and the controller enters the flowing state.
- R2: In the flowing state, with `flow_en` high and valid marks, a sampled `rx_level` at or above `hi_mark` moves the controller to the stopped state, and `xoff_req` is high from the next cycle on. A level below `hi_mark` raises nothing.
- R3: In the stopped state, with `flow_en` high and valid marks, a sampled `rx_level` at or below `lo_mark` returns the controller to flowing and raises `xon_req` on the next cycle. Levels strictly between the marks raise nothing.
- R4: A raised request stays high until a cycle in which `tx_ack` is high, and is low from the following cycle. One crossing yields exactly one request: a level that stays beyond the mark does not raise it again.
- R5: `xon_req` and `xoff_req` are never high together. A new crossing drops the opposite pending request in the same cycle that it raises its own.
- R6: The marks are invalid when `lo_mark` is zero or `hi_mark` is not greater than `lo_mark`. While they are invalid, the flow state and any pending request are held, and no level raises a new request; `tx_ack` still clears a pending request.
- R7: While `flow_en` is low, the controller is forced to the flowing state and both requests are low from the next cycle.
- R8: When `enh_mode`, `spec_det_en` and `rx_valid` are all high and `rx_char` equals `spec_char`, `spec_flag` and `irq` are both high on the next cycle. If any of the three enables is low, or the characters differ, neither output is affected.
- R9: A high `irq_clr` drops `irq` on the next cycle and leaves `spec_flag` unchanged. A high `flag_clr` drops `spec_flag` on the next cycle and leaves `irq` unchanged.
- R10: A match in the same cycle as a clear strobe wins: the output stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_en | input | 1 | Automatic in-band flow control enable |
| enh_mode | input | 1 | Enhanced mode enable (gates character detection) |
| spec_det_en | input | 1 | Special character detection enable |
| rx_level | input | LEVEL_W (8) | Current receive FIFO fill level |
| hi_mark | input | LEVEL_W (8) | Upper mark: stop request threshold |
| lo_mark | input | LEVEL_W (8) | Lower mark: resume request threshold |
| spec_char | input | CHAR_W (8) | Programmed special character |
| rx_valid | input | 1 | Strobe: `rx_char` holds a newly received character |
| rx_char | input | CHAR_W (8) | Received character |
| tx_ack | input | 1 | Transmitter has taken the pending request |
| irq_clr | input | 1 | Interrupt status read while this source is reported |
| flag_clr | input | 1 | Clear strobe for the special-character flag |
| xoff_req | output | 1 | Request to transmit the stop character |
| xon_req | output | 1 | Request to transmit the resume character |
| spec_flag | output | 1 | Sticky special-character match flag |
| irq | output | 1 | Interrupt request for a special-character match |

## Verification
The marks are tried with a level that approaches them from both sides and lands exactly on each mark, including the 64/100 case. This separates `>=`/`<=` from strict comparison and shows that levels between the marks are hysteresis, not triggers. Equal marks and a zero lower mark are driven while requests are pending, which shows holding apart from resetting. A crossing back before any acknowledge shows that the pending request is replaced. Matching characters are sent with each enable removed in turn, and together with clear strobes, which separates the gating terms from one another and shows the set-over-clear priority. A long random walk of the level with random acknowledges, mark changes and characters is then compared cycle by cycle with a reference model.

// File: rtl/xfc_pkg.sv
// Shared types for the in-band flow controller.
package xfc_pkg;
    // Flow state: flowing means the remote sender is allowed to transmit.
    typedef enum logic {
        FLOW_GO   = 1'b0,
        FLOW_STOP = 1'b1
    } flow_state_t;
endpackage

// File: rtl/xfc_level_watch.sv
// Compares the receive FIFO level against the upper and lower marks.
// Assumes: marks are stable programmed values; purely combinational.
// A pair of marks is valid only when lo is nonzero and hi is above lo.
module xfc_level_watch #(
    parameter int LEVEL_W = 8
) (
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] hi_mark,
    input  logic [LEVEL_W-1:0] lo_mark,
    output logic               marks_ok,
    output logic               at_high,
    output logic               at_low
);
    localparam logic [LEVEL_W-1:0] ZERO = '0;

    // Threshold compares and mark validity check.
    always_comb begin
        marks_ok = (lo_mark != ZERO) && (hi_mark > lo_mark);
        at_high  = (rx_level >= hi_mark);
        at_low   = (rx_level <= lo_mark);
    end
endmodule

// File: rtl/xfc_flow_fsm.sv
// Two-state hysteresis controller that raises one stop or resume request
// per threshold crossing and holds it until the transmitter acknowledges.
// Assumes: tx_ack is a one-cycle strobe; threshold flags come from
// xfc_level_watch in the same cycle.
module xfc_flow_fsm
    import xfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flow_en,
    input  logic marks_ok,
    input  logic at_high,
    input  logic at_low,
    input  logic tx_ack,
    output logic xoff_req,
    output logic xon_req
);
    flow_state_t state;
    logic        go_stop;
    logic        go_flow;

    // Decide crossings; only a valid, enabled pair of marks can trigger.
    always_comb begin
        go_stop = flow_en && marks_ok && (state == FLOW_GO)   && at_high;
        go_flow = flow_en && marks_ok && (state == FLOW_STOP) && at_low;
    end

    // Flow state register with forced return to flowing when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= FLOW_GO;
        else if (!flow_en) state <= FLOW_GO;
        else if (go_stop)  state <= FLOW_STOP;
        else if (go_flow)  state <= FLOW_GO;
    end

    // Pending request latches: a new crossing wins over the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !flow_en) begin
            xoff_req <= 1'b0;
            xon_req  <= 1'b0;
        end else if (go_stop) begin
            xoff_req <= 1'b1;
            xon_req  <= 1'b0;
        end else if (go_flow) begin
            xoff_req <= 1'b0;
            xon_req  <= 1'b1;
        end else if (tx_ack) begin
            xoff_req <= 1'b0;
            xon_req  <= 1'b0;
        end
    end

    // R5
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xoff_req, xon_req}));

    // R2
    xoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xoff_req) |-> $past(flow_en && marks_ok && at_high));

    // R3
    xon_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xon_req) |-> $past(flow_en && marks_ok && at_low));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((xoff_req || xon_req) && !tx_ack && flow_en) |=> (xoff_req || xon_req));

    // R6
    bad_marks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !marks_ok) |=> $stable(state));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> (!xoff_req && !xon_req));
endmodule

// File: rtl/xfc_char_match.sv
// Detects the programmed special character in the receive stream and keeps
// a sticky flag and an interrupt request, each with its own clear.
// Assumes: rx_valid marks one new character per strobe; set beats clear.
module xfc_char_match #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enh_mode,
    input  logic              spec_det_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [CHAR_W-1:0] spec_char,
    input  logic              irq_clr,
    input  logic              flag_clr,
    output logic              spec_flag,
    output logic              irq
);
    logic hit;

    // Gated equality compare of the received character.
    always_comb hit = enh_mode && spec_det_en && rx_valid && (rx_char == spec_char);

    // Sticky match flag; a hit in the clearing cycle keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n)        spec_flag <= 1'b0;
        else if (hit)      spec_flag <= 1'b1;
        else if (flag_clr) spec_flag <= 1'b0;
    end

    // Interrupt request; withdrawn by a status read of this source.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (hit)     irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    // R8
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_mode && spec_det_en && rx_valid && rx_char == spec_char) |=> (spec_flag && irq));

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(enh_mode && spec_det_en && rx_valid)) |=> !irq);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rx_valid && enh_mode && spec_det_en));
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
// Top of the in-band flow controller: threshold watch, hysteresis state
// machine and special-character matcher.
// Assumes: rx_level is the current receive FIFO count; all inputs are
// synchronous to clk.
module xonxoff_flow_ctrl #(
    parameter int LEVEL_W = 8,
    parameter int CHAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_en,
    input  logic              enh_mode,
    input  logic              spec_det_en,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] hi_mark,
    input  logic [LEVEL_W-1:0] lo_mark,
    input  logic [CHAR_W-1:0] spec_char,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              tx_ack,
    input  logic              irq_clr,
    input  logic              flag_clr,
    output logic              xoff_req,
    output logic              xon_req,
    output logic              spec_flag,
    output logic              irq
);
    logic marks_ok;
    logic at_high;
    logic at_low;

    xfc_level_watch #(.LEVEL_W(LEVEL_W)) u_watch (
        .rx_level (rx_level),
        .hi_mark  (hi_mark),
        .lo_mark  (lo_mark),
        .marks_ok (marks_ok),
        .at_high  (at_high),
        .at_low   (at_low)
    );

    xfc_flow_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .flow_en  (flow_en),
        .marks_ok (marks_ok),
        .at_high  (at_high),
        .at_low   (at_low),
        .tx_ack   (tx_ack),
        .xoff_req (xoff_req),
        .xon_req  (xon_req)
    );

    xfc_char_match #(.CHAR_W(CHAR_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .enh_mode    (enh_mode),
        .spec_det_en (spec_det_en),
        .rx_valid    (rx_valid),
        .rx_char     (rx_char),
        .spec_char   (spec_char),
        .irq_clr     (irq_clr),
        .flag_clr    (flag_clr),
        .spec_flag   (spec_flag),
        .irq         (irq)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!xoff_req && !xon_req && !spec_flag && !irq));
endmodule

// File: tb/xonxoff_flow_ctrl_test.sv
module xonxoff_flow_ctrl_test;
    localparam int LW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n, flow_en, enh_mode, spec_det_en, rx_valid, tx_ack, irq_clr, flag_clr;
    logic [LW-1:0] rx_level, hi_mark, lo_mark;
    logic [CW-1:0] spec_char, rx_char;
    logic xoff_req, xon_req, spec_flag, irq;

    int n_checks = 0;
    int n_errs = 0;

    // reference model state
    bit m_stop, m_xoff, m_xon, m_flag, m_irq;

    always #10 clk = ~clk;

    xonxoff_flow_ctrl #(.LEVEL_W(LW), .CHAR_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .enh_mode(enh_mode),
        .spec_det_en(spec_det_en), .rx_level(rx_level), .hi_mark(hi_mark),
        .lo_mark(lo_mark), .spec_char(spec_char), .rx_valid(rx_valid),
        .rx_char(rx_char), .tx_ack(tx_ack), .irq_clr(irq_clr),
        .flag_clr(flag_clr), .xoff_req(xoff_req), .xon_req(xon_req),
        .spec_flag(spec_flag), .irq(irq)
    );

    // Advance the model by one edge using the inputs stable at that edge.
    function automatic void model_edge();
        bit ok, hit;
        if (!rst_n) begin
            m_stop = 0; m_xoff = 0; m_xon = 0; m_flag = 0; m_irq = 0;
            return;
        end
        ok  = (lo_mark != 0) && (hi_mark > lo_mark);
        hit = enh_mode && spec_det_en && rx_valid && (rx_char == spec_char);
        if (!flow_en) begin
            m_stop = 0; m_xoff = 0; m_xon = 0;
        end else if (ok && !m_stop && rx_level >= hi_mark) begin
            m_stop = 1; m_xoff = 1; m_xon = 0;
        end else if (ok && m_stop && rx_level <= lo_mark) begin
            m_stop = 0; m_xoff = 0; m_xon = 1;
        end else if (tx_ack) begin
            m_xoff = 0; m_xon = 0;
        end
        if (hit) m_flag = 1; else if (flag_clr) m_flag = 0;
        if (hit) m_irq = 1;  else if (irq_clr)  m_irq = 0;
    endfunction

    task automatic check_bit(input string tag, input string what, input logic got, input bit exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic step(input string rtag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_bit(rtag, "xoff_req", xoff_req, m_xoff);
        check_bit(rtag, "xon_req", xon_req, m_xon);
        check_bit((rtag == "R1") ? "R1" : "R8", "spec_flag", spec_flag, m_flag);
        check_bit((rtag == "R1") ? "R1" : "R9", "irq", irq, m_irq);
        tx_ack = 0; irq_clr = 0; flag_clr = 0; rx_valid = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd7215));
        rst_n = 0; flow_en = 0; enh_mode = 0; spec_det_en = 0; rx_valid = 0;
        tx_ack = 0; irq_clr = 0; flag_clr = 0;
        rx_level = 0; hi_mark = 0; lo_mark = 0; spec_char = 0; rx_char = 0;
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1;

        // R2 / R3: marks 64 and 100, level approaching and landing on each mark
        flow_en = 1; lo_mark = 8'd64; hi_mark = 8'd100;
        rx_level = 8'd99;  step("R2");
        rx_level = 8'd100; step("R2");
        rx_level = 8'd120; step("R4");
        tx_ack = 1;        step("R4");
        rx_level = 8'd110; step("R4");
        rx_level = 8'd65;  step("R3");
        rx_level = 8'd64;  step("R3");
        rx_level = 8'd30;  step("R4");
        tx_ack = 1;        step("R4");
        rx_level = 8'd5;   step("R4");

        // R6: invalid marks with a pending request
        rx_level = 8'd100; step("R2");
        lo_mark = 8'd0; rx_level = 8'd10; step("R6");
        tx_ack = 1;     step("R6");
        lo_mark = 8'd90; hi_mark = 8'd90; rx_level = 8'd0; step("R6");
        rx_level = 8'd200; step("R6");
        lo_mark = 8'd64; hi_mark = 8'd100; rx_level = 8'd70; step("R6");

        // R5: crossing back before acknowledge replaces the pending request
        rx_level = 8'd20;  step("R5");
        rx_level = 8'd101; step("R5");
        rx_level = 8'd3;   step("R5");

        // R7: disable forces flowing and clears requests
        rx_level = 8'd150; step("R7");
        flow_en = 0;       step("R7");
        flow_en = 1; rx_level = 8'd80; step("R7");

        // R8: special character with each gate removed in turn
        spec_char = 8'h13; enh_mode = 1; spec_det_en = 0;
        rx_valid = 1; rx_char = 8'h13; step("R8");
        enh_mode = 0; spec_det_en = 1; rx_valid = 1; rx_char = 8'h13; step("R8");
        enh_mode = 1; rx_valid = 1; rx_char = 8'h11; step("R8");
        rx_char = 8'h13; step("R8");
        rx_valid = 1; step("R8");

        // R9: separate clears
        irq_clr = 1;  step("R9");
        flag_clr = 1; step("R9");

        // R10: set wins over clear
        rx_valid = 1; irq_clr = 1; flag_clr = 1; step("R10");
        check_bit("R10", "spec_flag kept", spec_flag, 1'b1);
        check_bit("R10", "irq kept", irq, 1'b1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                lo_mark = 8'($urandom_range(0, 80));
                hi_mark = 8'($urandom_range(0, 160));
            end
            if (r >= 3 && r < 5) flow_en = ~flow_en;
            if ($urandom_range(0, 3) == 0) begin
                enh_mode    = 1'($urandom_range(0, 1));
                spec_det_en = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 1) == 1) begin
                if (rx_level < 8'd250) rx_level = rx_level + 8'($urandom_range(0, 5));
            end else begin
                if (rx_level > 8'd5) rx_level = rx_level - 8'($urandom_range(0, 5));
            end
            tx_ack   = ($urandom_range(0, 3) == 0);
            rx_valid = ($urandom_range(0, 2) == 0);
            rx_char  = ($urandom_range(0, 3) == 0) ? spec_char : 8'($urandom_range(0, 255));
            irq_clr  = ($urandom_range(0, 5) == 0);
            flag_clr = ($urandom_range(0, 7) == 0);
            step("R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule